// File: doc/BRIEF.md
# Horizontal Clock Blanking Divider

This block produces the two complementary horizontal shift-clock phases of an image-sensor readout: one pair line (H1/H3) and the opposite pair line (H2/H4). Outside the horizontal blanking window both lines change level on every pixel clock. Inside the window, when the active blanking mode allows it, the toggle rate can be lowered by a programmable even divisor. The longer pulses that result are used for charge mixing during blanking.

A small register port sets a 4-bit width code and a 2-bit blanking mode. The block samples both at the first pixel clock of each blanking window and keeps them for the whole window. A write made during a window therefore has no effect on the window in progress. Generating the window, shaping the blanking patterns and the serial control link all belong to neighbouring logic.

Top module: `hclk_blank_div`

## Requirements
- R1: Reset is asynchronous and active-low, and its release takes effect after two clock edges. During reset and right after it, the pair-A output is 1, the pair-B output is 0, and both the width code and the mode are 0. A blanking window after reset with no write in between therefore toggles on every clock.
- R2: The pair-B output is always the inverse of the pair-A output.
- R3: At every clock edge where the blanking flag is sampled low, both outputs toggle.
- R4: A write lands in the configuration register only when the write enable is 1 and the address equals 0x34. The width code is taken from data bits [7:4] and the mode from bits [1:0]. Writes to any other address leave the behaviour unchanged.
- R5: When the latched width code is 0, the outputs toggle on every clock inside the blanking window.
- R6: When the latched width code N is between 1 and 15 and the latched mode is 0 or 1, the outputs toggle at the first edge of the window. After that, each level holds for exactly 2N clocks, which gives 1/(2N) of the pixel-rate toggle frequency.
- R7: When the latched mode is 2 or 3, the width code is ignored and the outputs toggle on every clock inside the window.
- R8: The width code and the mode are latched only at the first edge of a blanking window. Writes made during a window change nothing until the next window starts.
- R9: At the first edge after the window ends, the outputs return to toggling on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| blank_i | input | 1 | High while the horizontal blanking window is active |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 8 | Register address |
| cfg_wdata_i | input | 8 | Register write data |
| hclk_a_o | output | 1 | H1/H3 phase line |
| hclk_b_o | output | 1 | H2/H4 phase line |

## Verification
The assertions assume that `blank_i` and the register port are synchronous to the pixel clock. They also assume that each blanking window lasts at least one clock. The checks rely on the latched width and mode that the block itself holds, so the assertions need no assumption about when writes arrive. The stimulus changes every input only at falling clock edges. Its windows last between 9 and 63 clocks and are always separated by idle gaps. A write is placed inside a window to check R8.

// File: rtl/hbd_pkg.sv
package hbd_pkg;
  localparam int unsigned HBD_WIDTH_W   = 4;
  localparam int unsigned HBD_MODE_W    = 2;
  localparam int unsigned HBD_ADDR_W    = 8;
  localparam int unsigned HBD_DATA_W    = 8;
  localparam logic [7:0]  HBD_CFG_ADDR  = 8'h34;
  localparam int unsigned HBD_WIDTH_LSB = 4;
  localparam int unsigned HBD_MODE_LSB  = 0;
  localparam int unsigned HBD_WIDE_MODE_LIMIT = 2;

  typedef struct packed {
    logic [HBD_WIDTH_W-1:0] width;
    logic [HBD_MODE_W-1:0]  mode;
  } hbd_cfg_t;
endpackage

// File: rtl/hbd_rst_sync.sv
module hbd_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic stage1_q, stage2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_no = stage2_q;
endmodule

// File: rtl/hbd_cfg_regs.sv
module hbd_cfg_regs
  import hbd_pkg::*;
#(
  parameter int unsigned ADDR_W    = HBD_ADDR_W,
  parameter int unsigned DATA_W    = HBD_DATA_W,
  parameter logic [ADDR_W-1:0] CFG_ADDR = ADDR_W'(HBD_CFG_ADDR),
  parameter int unsigned WIDTH_LSB = HBD_WIDTH_LSB,
  parameter int unsigned MODE_LSB  = HBD_MODE_LSB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output hbd_cfg_t          cfg_o
);
  hbd_cfg_t cfg_q, cfg_d;
  logic     hit_en;

  assign hit_en = we_i && (addr_i == CFG_ADDR);

  always_comb begin
    cfg_d       = cfg_q;
    cfg_d.width = wdata_i[WIDTH_LSB +: HBD_WIDTH_W];
    cfg_d.mode  = wdata_i[MODE_LSB  +: HBD_MODE_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (hit_en) begin
      cfg_q <= cfg_d;
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^wdata_i;

  assign cfg_o = cfg_q;
endmodule

// File: rtl/hbd_div_core.sv
module hbd_div_core
  import hbd_pkg::*;
#(
  parameter int unsigned WIDTH_W = HBD_WIDTH_W,
  parameter int unsigned MODE_W  = HBD_MODE_W,
  parameter int unsigned WIDE_LIMIT = HBD_WIDE_MODE_LIMIT,
  localparam int unsigned MAX_HOLD = 2 * ((1 << WIDTH_W) - 1),
  localparam int unsigned CNT_W    = $clog2(MAX_HOLD)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               blank_i,
  input  logic [WIDTH_W-1:0] cfg_width_i,
  input  logic [MODE_W-1:0]  cfg_mode_i,
  output logic               toggle_o,
  output logic               blank_q_o,
  output logic               wide_q_o,
  output logic [WIDTH_W-1:0] act_n_o,
  output logic [CNT_W-1:0]   cnt_q_o
);
  logic               blank_q;
  logic               wide_q, wide_d;
  logic [WIDTH_W-1:0] act_n_q, act_n_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               start;
  logic               cfg_wide;
  logic [CNT_W-1:0]   term;
  logic               toggle;

  assign start    = blank_i && !blank_q;
  assign cfg_wide = (cfg_mode_i < MODE_W'(WIDE_LIMIT)) && (cfg_width_i != '0);

  always_comb begin
    wide_d  = start ? cfg_wide    : wide_q;
    act_n_d = start ? cfg_width_i : act_n_q;
    term    = CNT_W'({act_n_d, 1'b0}) - CNT_W'(1);
    toggle  = 1'b1;
    cnt_d   = '0;
    if (blank_i && wide_d && !start) begin
      if (cnt_q == term) begin
        toggle = 1'b1;
        cnt_d  = '0;
      end else begin
        toggle = 1'b0;
        cnt_d  = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blank_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      blank_q <= blank_i;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wide_q  <= 1'b0;
      act_n_q <= '0;
    end else if (start) begin
      wide_q  <= wide_d;
      act_n_q <= act_n_d;
    end
  end

  assign toggle_o  = toggle;
  assign blank_q_o = blank_q;
  assign wide_q_o  = wide_q;
  assign act_n_o   = act_n_q;
  assign cnt_q_o   = cnt_q;
endmodule

// File: rtl/hbd_phase_flop.sv
module hbd_phase_flop #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic q_o
);
  logic q, d;

  assign d = ~q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q <= RST_VAL;
    end else if (en_i) begin
      q <= d;
    end
  end

  assign q_o = q;
endmodule

// File: rtl/hclk_blank_div.sv
module hclk_blank_div
  import hbd_pkg::*;
#(
  parameter int unsigned WIDTH_W = HBD_WIDTH_W,
  parameter int unsigned MODE_W  = HBD_MODE_W,
  parameter int unsigned ADDR_W  = HBD_ADDR_W,
  parameter int unsigned DATA_W  = HBD_DATA_W,
  localparam int unsigned CNT_W  = $clog2(2 * ((1 << WIDTH_W) - 1)),
  localparam int unsigned N_PH   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              blank_i,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  output logic              hclk_a_o,
  output logic              hclk_b_o
);
  logic               rst_s;
  hbd_cfg_t           cfg;
  logic               toggle;
  logic               blank_q;
  logic               wide_q;
  logic [WIDTH_W-1:0] act_n;
  logic [CNT_W-1:0]   cnt_q;
  logic [N_PH-1:0]    ph;

  hbd_rst_sync u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_s)
  );

  hbd_cfg_regs #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_s),
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .cfg_o   (cfg)
  );

  hbd_div_core #(
    .WIDTH_W (WIDTH_W),
    .MODE_W  (MODE_W)
  ) u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_s),
    .blank_i     (blank_i),
    .cfg_width_i (cfg.width),
    .cfg_mode_i  (cfg.mode),
    .toggle_o    (toggle),
    .blank_q_o   (blank_q),
    .wide_q_o    (wide_q),
    .act_n_o     (act_n),
    .cnt_q_o     (cnt_q)
  );

  // Index 0 drives the H1/H3 line (reset high), index 1 the H2/H4 line (reset low)
  for (genvar g = 0; g < N_PH; g++) begin : g_phase
    hbd_phase_flop #(
      .RST_VAL ((g == 0) ? 1'b1 : 1'b0)
    ) u_ph (
      .clk_i  (clk_i),
      .rst_ni (rst_s),
      .en_i   (toggle),
      .q_o    (ph[g])
    );
  end

  assign hclk_a_o = ph[0];
  assign hclk_b_o = ph[1];
endmodule

// File: rtl/hbd_checker.sv
module hbd_checker #(
  parameter int unsigned WIDTH_W = 4,
  parameter int unsigned CNT_W   = 5
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               blank_i,
  input logic               blank_q,
  input logic               wide_q,
  input logic [WIDTH_W-1:0] act_n,
  input logic [CNT_W-1:0]   cnt_q,
  input logic               hclk_a,
  input logic               hclk_b
);
  logic [CNT_W-1:0] term_c;
  assign term_c = CNT_W'({act_n, 1'b0}) - CNT_W'(1);

  p_pair_complement_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hclk_a != hclk_b);

  p_pixel_rate_outside_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !blank_i |=> hclk_a != $past(hclk_a));

  p_window_entry_toggle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blank_i && !blank_q) |=> hclk_a != $past(hclk_a));

  p_hold_inside_wide_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blank_i && blank_q && wide_q && (cnt_q != term_c)) |=> $stable(hclk_a));

  p_cnt_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blank_q && wide_q) |-> (cnt_q <= term_c));

  p_narrow_window_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blank_i && blank_q && !wide_q) |=> hclk_a != $past(hclk_a));

  p_latched_stable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blank_i && blank_q) |=> ($stable(act_n) && $stable(wide_q)));
endmodule

bind hclk_blank_div hbd_checker #(
  .WIDTH_W (WIDTH_W),
  .CNT_W   (CNT_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_s),
  .blank_i (blank_i),
  .blank_q (blank_q),
  .wide_q  (wide_q),
  .act_n   (act_n),
  .cnt_q   (cnt_q),
  .hclk_a  (hclk_a_o),
  .hclk_b  (hclk_b_o)
);

// File: tb/hclk_blank_div_tb.sv
module hclk_blank_div_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       blank;
  logic       we;
  logic [7:0] addr;
  logic [7:0] wdata;
  logic       hclk_a, hclk_b;

  int    n_checks = 0;
  int    n_fails  = 0;
  string cur_tag  = "R1";
  bit    cmp_en   = 1'b0;

  always #2.5 clk = ~clk;

  hclk_blank_div dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .blank_i     (blank),
    .cfg_we_i    (we),
    .cfg_addr_i  (addr),
    .cfg_wdata_i (wdata),
    .hclk_a_o    (hclk_a),
    .hclk_b_o    (hclk_b)
  );

  // Behavioural reference: level age counted in edges since the last change
  bit       m_a;
  int       m_rel, m_age, m_n;
  bit       m_wide, m_bq;
  int       m_width, m_mode;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_a = 1'b1; m_rel = 0; m_age = 0; m_n = 0; m_wide = 1'b0; m_bq = 1'b0;
      m_width = 0; m_mode = 0;
    end else if (m_rel < 2) begin
      m_rel++;
    end else begin
      bit st;
      st = blank && !m_bq;
      if (st) begin
        m_n    = m_width;
        m_wide = (m_mode < 2) && (m_width != 0);
      end
      if (blank && m_wide) begin
        if (st || m_age == 2 * m_n) begin m_a = !m_a; m_age = 1; end
        else m_age++;
      end else begin
        m_a = !m_a; m_age = 1;
      end
      if (we && addr == 8'h34) begin
        m_width = int'(wdata[7:4]);
        m_mode  = int'(wdata[1:0]);
      end
      m_bq = blank;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en) begin
      check({cur_tag, " pair A"}, int'(hclk_a), int'(m_a));
      check("R2 pair B inverse", int'(hclk_b), int'(!m_a));
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual %0d cycles expected under 100000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; addr = 8'h00; wdata = 8'h00;
  endtask

  task automatic idle(input int n, input string tag);
    cur_tag = tag;
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Runs one window of len clocks; every full level inside must last hold clocks
  task automatic window(input int hold, input int len, input string tag,
                        input bit mid_wr, input logic [7:0] mid_d);
    bit q[$];
    int run, full_runs, bad;
    @(negedge clk);
    cur_tag = tag;
    blank = 1'b1;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      q.push_back(hclk_a);
      if (mid_wr && i == 2) begin we = 1'b1; addr = 8'h34; wdata = mid_d; end
      else begin we = 1'b0; addr = 8'h00; wdata = 8'h00; end
    end
    blank = 1'b0;
    cur_tag = "R9";
    run = 1; full_runs = 0; bad = 0;
    for (int i = 1; i < q.size(); i++) begin
      if (q[i] != q[i-1]) begin
        full_runs++;
        if (run != hold) bad = run;
        run = 1;
      end else run++;
    end
    check({tag, " level length"}, (bad != 0) ? bad : hold, hold);
    check({tag, " full levels seen"}, int'(full_runs > 0), 1);
  endtask

  task automatic exit_check();
    bit p;
    p = hclk_a;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R9 pixel rate after window", int'(hclk_a), int'(!p));
      p = hclk_a;
    end
  endtask

  initial begin
    rst_n = 1'b0; blank = 1'b0; we = 1'b0; addr = 8'h00; wdata = 8'h00;
    repeat (3) @(negedge clk);
    check("R1 reset pair A", int'(hclk_a), 1);
    check("R1 reset pair B", int'(hclk_b), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 held after release pair A", int'(hclk_a), 1);
    cmp_en = 1'b1;
    idle(4, "R3");
    // R1: registers cleared, so the window runs at pixel rate
    window(1, 9, "R1", 1'b0, 8'h00);
    exit_check();
    // R5, R6, R7: every width in modes 0, 1 and 2
    for (int md = 0; md < 3; md++) begin
      for (int w = 0; w < 16; w++) begin
        int hold;
        hold = (md < 2 && w != 0) ? 2 * w : 1;
        wr(8'h34, {4'(w), 2'b00, 2'(md)});
        idle(3, "R3");
        window(hold, (hold > 1) ? 2 * hold + 3 : 9,
               (w == 0) ? "R5" : ((md < 2) ? "R6" : "R7"), 1'b0, 8'h00);
        exit_check();
      end
    end
    // R7: mode 3 also ignores the width code
    wr(8'h34, {4'd7, 2'b00, 2'd3});
    idle(3, "R3");
    window(1, 9, "R7", 1'b0, 8'h00);
    // R4: a write to another address is ignored
    wr(8'h34, 8'h00);
    wr(8'h35, 8'h50);
    idle(3, "R3");
    window(1, 9, "R4", 1'b0, 8'h00);
    // R4: data bits [3:2] carry nothing; width 3 in mode 1 gives hold 6
    wr(8'h34, 8'h3D);
    idle(3, "R3");
    window(6, 15, "R4", 1'b0, 8'h00);
    // R8: a write inside a window applies only from the next window
    wr(8'h34, {4'd2, 2'b00, 2'd0});
    idle(3, "R3");
    window(4, 20, "R8", 1'b1, {4'd5, 2'b00, 2'd2});
    idle(3, "R3");
    window(1, 9, "R8", 1'b0, 8'h00);
    wr(8'h34, {4'd5, 2'b00, 2'd1});
    idle(3, "R3");
    window(10, 23, "R8", 1'b0, 8'h00);
    exit_check();
    idle(4, "R3");
    cmp_en = 1'b0;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end
endmodule